// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiply Unit

This unit multiplies two operand bytes and returns a 16-bit product two clock cycles after a start strobe. A three-bit mode picks the operand signedness (both unsigned, both signed, or a signed first operand with an unsigned second operand). It also picks integer or fractional form. Fractional form doubles the product by shifting it left one place, so that two fixed-point values with the binary point after the top bit give a result in the same format.

The product goes out as a high byte and a low byte, meant for a fixed pair of destination registers: the high byte to the odd register, the low byte to the even one. The surrounding datapath writes both registers and the zero and carry flags when the done strobe is high. No other flag is touched. Operand fetch, register writes and instruction decode sit outside the block.

Internally the second operand is split into equal slices. Each slice is multiplied by the sign-extended first operand in the first cycle and the partial products are registered. The second cycle sums them, applies the fractional shift and derives the flags.

Top module: `mulx_unit`

## Requirements
- R1: `mode[1:0]` selects signedness: 00 unsigned by unsigned, 01 signed by signed, 10 signed first operand (two's complement) by unsigned second operand, 11 behaves as 00. `mode[2]` = 1 selects fractional form.
- R2: In integer form, `{res_hi,res_lo}` equals the low 16 bits of the product of the operands as the mode interprets them.
- R3: In fractional form, the result is that 16-bit product shifted left by one bit. Bit 0 becomes 0 and the product's top bit is dropped.
- R4: `flag_c` equals bit 15 of the product before any fractional shift.
- R5: `flag_z` is 1 exactly when the final 16-bit result (after any shift) is zero.
- R6: A start accepted at a rising edge makes `done` high after the next rising edge, for exactly one cycle. The result and flags are valid while `done` is high.
- R7: A start seen while an operation is in flight, or in the cycle where `done` is high, is ignored and does not change the result. A start in the cycle right after `done` is accepted.
- R8: After reset, `done`, the result bytes and both flags are 0. The result and the flags keep their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply with the present operands and mode |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| mode | input | 3 | Bits 1:0 signedness, bit 2 fractional form |
| done | output | 1 | One-cycle strobe: write result and flags |
| res_hi | output | 8 | High byte of result (odd destination register) |
| res_lo | output | 8 | Low byte of result (even destination register) |
| flag_z | output | 1 | Zero flag of the last result |
| flag_c | output | 1 | Carry flag of the last result |

## Verification
A new start request can land in the same cycle as the done strobe of the previous operation, and also in the cycle between acceptance and completion. The bench provokes both by holding start high over many cycles while changing the operands every cycle. Each collision is judged against a behavioural model of the accept, compute and done states. The model expects exactly one accepted operation per three cycles, and the reported product must belong to the operands present at the accepted edge, never to those offered during the busy or done cycle.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

  typedef enum logic [1:0] {
    SG_UU  = 2'b00,
    SG_SS  = 2'b01,
    SG_SU  = 2'b10,
    SG_RSV = 2'b11
  } sign_mode_e;

  // first operand is two's complement in SS and SU
  function automatic logic first_signed(input sign_mode_e m);
    return (m == SG_SS) || (m == SG_SU);
  endfunction

  // second operand is two's complement only in SS
  function automatic logic second_signed(input sign_mode_e m);
    return (m == SG_SS);
  endfunction

endpackage

// File: rtl/mulx_slice.sv
module mulx_slice #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic [W-1:0]      a,
  input  logic              a_sgn,
  input  logic [SW-1:0]     bs,
  input  logic              bs_sgn,
  output logic [W+SW+1:0]   pp
);
  localparam int PPW = W + SW + 2;

  function automatic logic signed [PPW-1:0] widen_a(input logic [W-1:0] v, input logic s);
    return $signed({{(SW+2){s & v[W-1]}}, v});
  endfunction

  function automatic logic signed [PPW-1:0] widen_b(input logic [SW-1:0] v, input logic s);
    return $signed({{(W+2){s & v[SW-1]}}, v});
  endfunction

  logic signed [PPW-1:0] prod;
  assign prod = widen_a(a, a_sgn) * widen_b(bs, bs_sgn);
  assign pp   = prod;

endmodule

// File: rtl/mulx_finish.sv
module mulx_finish #(
  parameter int W   = 8,
  parameter int NS  = 2,
  parameter int SW  = 4,
  parameter int PPW = 14
) (
  input  logic [NS-1:0][PPW-1:0] pp,
  input  logic                   frac,
  output logic [2*W-1:0]         result,
  output logic                   z,
  output logic                   c
);
  localparam int PW = 2 * W;
  localparam int XW = 2 * W + 2;

  function automatic logic [PW-1:0] accumulate(input logic [NS-1:0][PPW-1:0] v);
    logic [PW-1:0]        acc;
    logic signed [XW-1:0] wide;
    acc = '0;
    for (int i = 0; i < NS; i++) begin
      wide = XW'($signed(v[i]));
      acc  = acc + (wide[PW-1:0] << (i * SW));
    end
    return acc;
  endfunction

  function automatic logic [PW-1:0] frac_align(input logic [PW-1:0] raw, input logic f);
    return f ? {raw[PW-2:0], 1'b0} : raw;
  endfunction

  logic [PW-1:0] raw;
  assign raw    = accumulate(pp);
  assign c      = raw[PW-1];
  assign result = frac_align(raw, frac);
  assign z      = ~|result;

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
  import mulx_pkg::*;
#(
  parameter int W  = 8,
  parameter int NS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   mode,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_z,
  output logic         flag_c
);
  localparam int SW  = W / NS;
  localparam int PPW = W + SW + 2;
  localparam int PW  = 2 * W;

  sign_mode_e sgn;
  logic       frac_in, a_sgn, b_sgn;
  assign sgn     = sign_mode_e'(mode[1:0]);
  assign frac_in = mode[2];
  assign a_sgn   = first_signed(sgn);
  assign b_sgn   = second_signed(sgn);

  // named events for checking
  logic s1_valid, done_q, idle, accept;
  assign idle   = !s1_valid && !done_q;
  assign accept = start && idle;

  logic [NS-1:0][PPW-1:0] pp_d, pp_q;

  for (genvar g = 0; g < NS; g++) begin : g_slice
    localparam bit LAST = (g == NS - 1);
    mulx_slice #(.W(W), .SW(SW)) u_slice (
      .a      (opa),
      .a_sgn  (a_sgn),
      .bs     (opb[g*SW +: SW]),
      .bs_sgn (b_sgn & LAST),
      .pp     (pp_d[g])
    );
  end

  logic frac_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      frac_q   <= 1'b0;
      pp_q     <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        pp_q   <= pp_d;
        frac_q <= frac_in;
      end
    end
  end

  logic [PW-1:0] res_d, res_q;
  logic          z_d, c_d, z_q, c_q;

  mulx_finish #(.W(W), .NS(NS), .SW(SW), .PPW(PPW)) u_finish (
    .pp     (pp_q),
    .frac   (frac_q),
    .result (res_d),
    .z      (z_d),
    .c      (c_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
    end else begin
      done_q <= s1_valid;
      if (s1_valid) begin
        res_q <= res_d;
        z_q   <= z_d;
        c_q   <= c_d;
      end
    end
  end

  assign done   = done_q;
  assign res_hi = res_q[PW-1:W];
  assign res_lo = res_q[W-1:0];
  assign flag_z = z_q;
  assign flag_c = c_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  accept_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_valid);

  // R6
  stage_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (done_q && !s1_valid));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |=> !s1_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable({res_q, z_q, c_q}));

  // R3
  frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && frac_q) |-> (res_q[0] == 1'b0));

  // R4 R5
  zero_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && z_q) |-> !c_q);

endmodule

// File: tb/mulx_unit_bench.sv
`timescale 1ns/1ps
module mulx_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n, start;
  logic [7:0] opa, opb;
  logic [2:0] mode;
  logic       done, flag_z, flag_c;
  logic [7:0] res_hi, res_lo;

  always #2 clk = ~clk;

  mulx_unit u_mulx_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb), .mode(mode),
    .done(done), .res_hi(res_hi), .res_lo(res_lo), .flag_z(flag_z), .flag_c(flag_c)
  );

  int    n_run = 0, n_fail = 0;
  string tag = "R8";
  bit    running = 1'b0;

  // behavioural reference: 0 idle, 1 computing, 2 done cycle
  int         st;
  logic [7:0] ma, mb;
  logic [2:0] mm;
  logic       e_done, e_z, e_c;
  logic [15:0] e_res;

  function automatic logic [17:0] ref_mul(input logic [7:0] a, input logic [7:0] b, input logic [2:0] m);
    int va, vb, p;
    logic [15:0] raw, fin;
    va = int'(a);
    vb = int'(b);
    if ((m[1:0] == 2'd1 || m[1:0] == 2'd2) && a[7]) va = va - 256;
    if (m[1:0] == 2'd1 && b[7]) vb = vb - 256;
    p   = va * vb;
    raw = p[15:0];
    fin = m[2] ? (raw * 16'd2) : raw;
    return {(fin == 16'd0), raw[15], fin};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      st <= 0; e_done <= 1'b0; e_res <= '0; e_z <= 1'b0; e_c <= 1'b0;
    end else begin
      case (st)
        0: if (start) begin ma <= opa; mb <= opb; mm <= mode; st <= 1; end
        1: begin st <= 2; e_done <= 1'b1; {e_z, e_c, e_res} <= ref_mul(ma, mb, mm); end
        default: begin st <= 0; e_done <= 1'b0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(done == e_done, (tag == "R7") ? "R7" : "R6", "done", done, e_done);
      chk({res_hi, res_lo} == e_res, e_done ? tag : "R8", "result", {res_hi, res_lo}, e_res);
      chk(flag_z == e_z, "R5", "flag_z", flag_z, e_z);
      chk(flag_c == e_c, "R4", "flag_c", flag_c, e_c);
    end
  end

  task automatic op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] m, input string t);
    @(negedge clk);
    tag = t; start = 1'b1; opa = a; opb = b; mode = m;
    @(negedge clk);
    start = 1'b0; opa = 8'($urandom); opb = 8'($urandom); mode = 3'($urandom);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; opa = '0; opb = '0; mode = '0;
    repeat (3) @(negedge clk);
    chk({done, res_hi, res_lo, flag_z, flag_c} == '0, "R8", "reset state",
        {done, res_hi, res_lo, flag_z, flag_c}, 0);
    rst_n = 1'b1; running = 1'b1;

    op(8'hFF, 8'hFF, 3'b000, "R2");   // FE01, C=1
    op(8'h0C, 8'h0B, 3'b000, "R2");   // 0084
    op(8'h80, 8'h80, 3'b001, "R1");   // signed: 4000
    op(8'hFF, 8'h01, 3'b001, "R1");   // -1: FFFF
    op(8'hFF, 8'hFF, 3'b010, "R1");   // -1*255 = FF01
    op(8'h05, 8'hFE, 3'b010, "R1");   // 5*254 = 04F6
    op(8'hFF, 8'hFF, 3'b011, "R1");   // code 11 as unsigned: FE01
    op(8'h80, 8'h80, 3'b100, "R3");   // 4000<<1 = 8000
    op(8'hC0, 8'hC0, 3'b100, "R3");   // 9000 -> 2000, C=1
    op(8'h80, 8'h80, 3'b101, "R3");   // signed frac 8000
    op(8'hC0, 8'h40, 3'b110, "R3");   // -64*64 = F000 -> E000
    op(8'h00, 8'h9A, 3'b001, "R5");   // zero
    op(8'h00, 8'h77, 3'b101, "R5");   // zero frac
    repeat (4) @(negedge clk);        // hold, R8

    // start held high: collisions with busy and done cycles
    tag = "R7";
    for (int i = 0; i < 40; i++) begin
      start = 1'b1; opa = 8'($urandom); opb = 8'($urandom); mode = 3'($urandom);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);

    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      start = 1'($urandom); opa = 8'($urandom); opb = 8'($urandom); mode = 3'($urandom);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule